// File: doc/BRIEF.md
# Console UART register front-end

This block is the register and interrupt side of a small console UART that has no serial line of its own. A 32-bit register bus on one side reads and writes a set of registers. On the other side sit two byte queues: a backend fills the receive queue and drains the transmit queue. A data read takes a byte from the receive queue. A data write puts a byte into the transmit queue. Every data access sends a one-cycle pulse to the backend. The backend pulses a notification input whenever it has moved bytes.

The flag and raw-interrupt state does not follow queue occupancy on its own. It changes only on data accesses and on backend notifications. The interrupt request is a one-cycle pulse, raised only when a masked status bit turns on that was off in a stored shadow copy.

A bus access is presented for one cycle with `req_i`. Its read data and its error outputs appear on the registered outputs after the next rising edge and stay there for one cycle.

Top module: `cuart_front`

## Requirements
- R1: After reset the flag register (offset 0x018) reads 0x90: TX-empty (bit 7) and RX-empty (bit 4) are set, and RX-full (bit 6), TX-full (bit 5) and busy (bit 3) are clear. The raw-status, mask and masked-status registers read 0, and `irq_o` is low.
- R2: A write to the data register (offset 0x000) pushes `wdata_i[7:0]` into the transmit queue, or drops it if the queue is full. The write sets busy and clears TX-empty. If the queue is full afterwards, it sets TX-full and clears the TX raw interrupt. The backend sees the bytes in order on `tx_byte_o` while `tx_valid_o` is high.
- R3: A read of the data register returns the oldest receive byte and removes it, or returns 0 when the queue is empty. It always clears RX-full. If the queue is empty afterwards, it sets RX-empty and clears the RX raw interrupt.
- R4: On `notify_i`, a non-empty receive queue clears RX-empty, sets the RX raw interrupt, and also sets RX-full if the queue holds DEPTH bytes. A non-full transmit queue clears TX-full and sets the TX raw interrupt. If the transmit queue is also empty, the notification clears busy and sets TX-empty.
- R5: The RX interrupt is bit 4 and the TX interrupt is bit 5 of the raw-status (0x03C), mask (0x038) and clear (0x044) registers. All other bits read 0. The masked-status register (0x040) reads raw AND mask.
- R6: A write to the clear register clears every raw bit that is set in the written value. A read of the clear register returns 0 and pulses `err_o`.
- R7: `irq_o` pulses for one cycle only when raw AND mask holds a bit that was clear in the shadow copy. The shadow is then updated to the new masked value. An update that turns on no new bit leaves `irq_o` low.
- R8: Writes to the flag, raw-status and masked-status registers are ignored. The receive-status register (0x004) always reads 0, and writes to it have no effect.
- R9: `size_i` encodes the access width: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit. Widths 0 to 2 are accepted on every register. A 64-bit access pulses `fatal_o`, returns 0 and changes no state.
- R10: An access to any offset other than the seven register offsets reads 0, changes no state and pulses `err_o`.
- R11: Every accepted data read or write pulses `kick_o` for one cycle. No other access does.
- R12: Backend pushes and pops change the flags and raw interrupts only at the next notification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request, one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| size_i | input | 2 | Access width code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| err_o | output | 1 | Invalid offset or read of the clear register |
| fatal_o | output | 1 | 64-bit access |
| rx_push_i | input | 1 | Backend pushes a byte into the receive queue |
| rx_byte_i | input | 8 | Byte pushed by the backend |
| tx_pop_i | input | 1 | Backend takes the head of the transmit queue |
| tx_byte_o | output | 8 | Head of the transmit queue |
| tx_valid_o | output | 1 | Transmit queue is not empty |
| notify_i | input | 1 | Backend notification |
| kick_o | output | 1 | Pulse to the backend on each data access |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
The transmit path is driven with one write more than DEPTH and a second one beyond that. This separates accepted bytes from dropped ones and shows exactly when TX-full and the TX raw bit change. The receive path is tried three ways: partly filled, completely filled, and drained past empty. These show the RX-full rule, the RX-empty rule and the zero read apart. All four mask values are swept against a raw value with both bits set. Every byte offset in the low register window that maps to no register is read. Interrupt pulses are checked in three situations: a mask write that enables an active bit, a repeated notification that adds nothing new, and a clear followed by a re-set. This shows that edge detection works against the shadow copy and not against the level.

// File: rtl/cuart_pkg.sv
package cuart_pkg;
  localparam logic [11:0] OFF_DATA = 12'h000;
  localparam logic [11:0] OFF_RSTS = 12'h004;
  localparam logic [11:0] OFF_FLAG = 12'h018;
  localparam logic [11:0] OFF_MASK = 12'h038;
  localparam logic [11:0] OFF_RAW  = 12'h03C;
  localparam logic [11:0] OFF_MIS  = 12'h040;
  localparam logic [11:0] OFF_CLR  = 12'h044;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} acc_size_e;

  // flag register bits 7..3
  typedef struct packed {
    logic txe;
    logic rxf;
    logic txf;
    logic rxe;
    logic busy;
  } flags_t;

  // interrupt bits 5..4
  typedef struct packed {
    logic tx;
    logic rx;
  } irqv_t;
endpackage

// File: rtl/cuart_fifo.sv
module cuart_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign do_push = push_i && (cnt_q != CNT_W'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/cuart_irq.sv
module cuart_irq #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] masked_i,
  output logic         irq_o
);
  logic [W-1:0] shadow_q;
  logic         irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      irq_q    <= |(masked_i & ~shadow_q);
      shadow_q <= masked_i;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/cuart_front.sv
module cuart_front
  import cuart_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              fatal_o,
  input  logic              rx_push_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_pop_i,
  output logic [7:0]        tx_byte_o,
  output logic              tx_valid_o,
  input  logic              notify_i,
  output logic              kick_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  flags_t fr_q, fr_n;
  irqv_t  raw_q, raw_n, mask_q, mask_n;

  logic [CNT_W-1:0] rx_cnt, tx_cnt, rx_after, tx_after;
  logic [7:0]       rx_head;
  logic             acc, bad_size, mapped, dat_rd, dat_wr;
  logic             hit_data, hit_rsts, hit_flag, hit_mask, hit_raw, hit_mis, hit_clr;
  logic [31:0]      rd_val;
  logic [31:0]      rdata_q;
  logic             err_q, fatal_q, kick_q;

  // decode: exact register base offsets only
  assign hit_data = (addr_i == ADDR_W'(OFF_DATA));
  assign hit_rsts = (addr_i == ADDR_W'(OFF_RSTS));
  assign hit_flag = (addr_i == ADDR_W'(OFF_FLAG));
  assign hit_mask = (addr_i == ADDR_W'(OFF_MASK));
  assign hit_raw  = (addr_i == ADDR_W'(OFF_RAW));
  assign hit_mis  = (addr_i == ADDR_W'(OFF_MIS));
  assign hit_clr  = (addr_i == ADDR_W'(OFF_CLR));
  assign mapped   = hit_data | hit_rsts | hit_flag | hit_mask | hit_raw | hit_mis | hit_clr;

  assign bad_size = req_i && (size_i == SZ_D);
  assign acc      = req_i && (size_i != SZ_D);
  assign dat_rd   = acc && !we_i && hit_data;
  assign dat_wr   = acc && we_i && hit_data;

  cuart_fifo #(.DEPTH(DEPTH), .W(8)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (rx_push_i),
    .din_i  (rx_byte_i),
    .pop_i  (dat_rd),
    .dout_o (rx_head),
    .count_o(rx_cnt)
  );

  cuart_fifo #(.DEPTH(DEPTH), .W(8)) u_txq (
    .clk_i, .rst_ni,
    .push_i (dat_wr),
    .din_i  (wdata_i[7:0]),
    .pop_i  (tx_pop_i),
    .dout_o (tx_byte_o),
    .count_o(tx_cnt)
  );

  assign tx_valid_o = (tx_cnt != '0);

  // occupancy as seen after this cycle's data access; backend moves count at next notify
  assign rx_after = rx_cnt - CNT_W'(dat_rd && (rx_cnt != '0));
  assign tx_after = tx_cnt + CNT_W'(dat_wr && (tx_cnt != FULL));

  always_comb begin
    fr_n   = fr_q;
    raw_n  = raw_q;
    mask_n = mask_q;
    if (dat_rd) begin
      fr_n.rxf = 1'b0;
      if (rx_after == '0) begin
        fr_n.rxe = 1'b1;
        raw_n.rx = 1'b0;
      end
    end
    if (dat_wr) begin
      fr_n.busy = 1'b1;
      fr_n.txe  = 1'b0;
      if (tx_after == FULL) begin
        fr_n.txf = 1'b1;
        raw_n.tx = 1'b0;
      end
    end
    if (acc && we_i && hit_mask) mask_n = irqv_t'(wdata_i[5:4]);
    if (acc && we_i && hit_clr)  raw_n  = raw_n & ~irqv_t'(wdata_i[5:4]);
    if (notify_i) begin
      if (rx_after != '0) begin
        fr_n.rxe = 1'b0;
        raw_n.rx = 1'b1;
        if (rx_after == FULL) fr_n.rxf = 1'b1;
      end
      if (tx_after != FULL) begin
        fr_n.txf = 1'b0;
        raw_n.tx = 1'b1;
        if (tx_after == '0) begin
          fr_n.busy = 1'b0;
          fr_n.txe  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_data)      rd_val = (rx_cnt != '0) ? {24'b0, rx_head} : 32'b0;
    else if (hit_flag) rd_val = {24'b0, fr_q, 3'b0};
    else if (hit_raw)  rd_val = {26'b0, raw_q, 4'b0};
    else if (hit_mask) rd_val = {26'b0, mask_q, 4'b0};
    else if (hit_mis)  rd_val = {26'b0, raw_q & mask_q, 4'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fr_q    <= '{txe: 1'b1, rxe: 1'b1, default: 1'b0};
      raw_q   <= '0;
      mask_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      fatal_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      fr_q    <= fr_n;
      raw_q   <= raw_n;
      mask_q  <= mask_n;
      rdata_q <= (acc && !we_i) ? rd_val : 32'b0;
      err_q   <= acc && (!mapped || (!we_i && hit_clr));
      fatal_q <= bad_size;
      kick_q  <= dat_rd || dat_wr;
    end
  end

  cuart_irq #(.W(2)) u_irq (
    .clk_i, .rst_ni,
    .masked_i(raw_n & mask_n),
    .irq_o
  );

  assign rdata_o = rdata_q;
  assign err_o   = err_q;
  assign fatal_o = fatal_q;
  assign kick_o  = kick_q;
endmodule

// File: rtl/cuart_front_chk.sv
module cuart_front_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        size_i,
  input logic              kick_o,
  input logic              fatal_o,
  input logic              err_o,
  input logic              irq_o,
  input logic [4:0]        flags_i,
  input logic [1:0]        raw_i,
  input logic [1:0]        mask_i
);
  // flags_i = {txe, rxf, txf, rxe, busy}
  assert_fatal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'd3) |=> (fatal_o && !kick_o));

  assert_kick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'd3 && addr_i == '0) |=> kick_o);

  assert_no_kick_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && addr_i == '0) |=> !kick_o);

  assert_tx_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_i[4] && flags_i[0]) && !(flags_i[4] && flags_i[2]));

  assert_rx_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flags_i[3] && flags_i[1]));

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_i & mask_i) != 2'b00));

  assert_err_alone_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!kick_o && !fatal_o));
endmodule

bind cuart_front cuart_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_i),
  .addr_i (addr_i),
  .size_i (size_i),
  .kick_o (kick_o),
  .fatal_o(fatal_o),
  .err_o  (err_o),
  .irq_o  (irq_o),
  .flags_i(fr_q),
  .raw_i  (raw_q),
  .mask_i (mask_q)
);

// File: tb/cuart_front_test.sv
module cuart_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam logic [11:0] A_DATA = 12'h000, A_RSTS = 12'h004, A_FLAG = 12'h018,
                          A_MASK = 12'h038, A_RAW = 12'h03C, A_MIS = 12'h040, A_CLR = 12'h044;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0;
  logic [11:0] addr_i = '0;
  logic [1:0]  size_i = 2'd2;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic err_o, fatal_o, kick_o, irq_o, tx_valid_o;
  logic rx_push_i = 0, tx_pop_i = 0, notify_i = 0;
  logic [7:0] rx_byte_i = '0, tx_byte_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] r_data;
  logic r_err, r_fatal, r_kick, r_irq;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cuart_front #(.DEPTH(DEPTH), .ADDR_W(12)) uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd);
    req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    @(negedge clk_i);
    r_data = rdata_o; r_err = err_o; r_fatal = fatal_o; r_kick = kick_o; r_irq = irq_o;
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(input logic [11:0] a); acc(1'b0, a, 2'd2, 32'h0); endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); acc(1'b1, a, 2'd2, d); endtask

  task automatic notify();
    notify_i = 1; @(negedge clk_i); r_irq = irq_o; notify_i = 0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_push_i = 1; rx_byte_i = b; @(negedge clk_i); rx_push_i = 0;
  endtask

  task automatic pop();
    tx_pop_i = 1; @(negedge clk_i); tx_pop_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    rd(A_FLAG); chk("R1 flag", r_data, 32'h90);
    rd(A_RAW);  chk("R1 raw", r_data, 0);
    rd(A_MASK); chk("R1 mask", r_data, 0);
    rd(A_MIS);  chk("R1 mis", r_data, 0);

    // R12 backend push does not move flags; R4 notify does
    push(8'hA1); push(8'hA2);
    rd(A_FLAG); chk("R12 flag before notify", r_data, 32'h90);
    chk("R10 mapped no err", {31'b0, r_err}, 0);
    chk("R11 no kick on flag", {31'b0, r_kick}, 0);
    notify(); chk("R7 no irq masked off", {31'b0, r_irq}, 0);
    rd(A_FLAG); chk("R4 flag", r_data, 32'h80);
    rd(A_RAW);  chk("R4 raw", r_data, 32'h30);

    // R7 mask enabling an active bit pulses; repeat notify does not
    wr(A_MASK, 32'h10); chk("R7 irq on mask", {31'b0, r_irq}, 1);
    @(negedge clk_i); chk("R7 one cycle", {31'b0, irq_o}, 0);
    rd(A_MIS); chk("R5 mis", r_data, 32'h10);
    notify(); chk("R7 no new bit", {31'b0, r_irq}, 0);

    // R3 receive pops
    rd(A_DATA); chk("R3 byte0", r_data, 32'hA1); chk("R11 kick rd", {31'b0, r_kick}, 1);
    rd(A_FLAG); chk("R3 flag nonempty", r_data, 32'h80);
    rd(A_DATA); chk("R3 byte1", r_data, 32'hA2);
    rd(A_FLAG); chk("R3 flag empty", r_data, 32'h90);
    rd(A_RAW);  chk("R3 rx raw cleared", r_data, 32'h20);
    rd(A_DATA); chk("R3 empty read", r_data, 0); chk("R11 kick empty rd", {31'b0, r_kick}, 1);

    wr(A_MASK, 32'h30); chk("R7 irq tx enable", {31'b0, r_irq}, 1);

    // R2 transmit sweep past full
    for (int k = 1; k <= DEPTH + 2; k++) begin
      wr(A_DATA, 32'h40 + k - 1);
      chk("R11 kick wr", {31'b0, r_kick}, 1);
      chk("R7 no irq on tx write", {31'b0, r_irq}, 0);
      rd(A_FLAG);
      chk("R2 flag", r_data, (k >= DEPTH) ? 32'h38 : 32'h18);
    end
    rd(A_RAW); chk("R2 tx raw cleared", r_data, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 tx valid", {31'b0, tx_valid_o}, 1);
      chk("R2 tx order", {24'b0, tx_byte_o}, 32'h40 + i);
      pop();
    end
    chk("R2 tx drained", {31'b0, tx_valid_o}, 0);
    rd(A_FLAG); chk("R12 flag after pops", r_data, 32'h38);
    notify(); chk("R7 irq tx", {31'b0, r_irq}, 1);
    rd(A_FLAG); chk("R4 tx empty flag", r_data, 32'h90);
    rd(A_RAW);  chk("R4 tx raw", r_data, 32'h20);

    // R4 receive full
    for (int i = 0; i <= DEPTH; i++) push(8'hB0 + 8'(i));
    notify(); chk("R7 irq rx", {31'b0, r_irq}, 1);
    rd(A_FLAG); chk("R4 rx full flag", r_data, 32'hC0);
    rd(A_RAW);  chk("R4 raw both", r_data, 32'h30);
    acc(1'b0, A_DATA, 2'd0, 0); chk("R9 8-bit read", r_data, 32'hB0);
    rd(A_FLAG); chk("R3 rx full cleared", r_data, 32'h80);

    // R9 64-bit access
    acc(1'b0, A_DATA, 2'd3, 0);
    chk("R9 fatal", {31'b0, r_fatal}, 1); chk("R9 no kick", {31'b0, r_kick}, 0);
    chk("R9 data 0", r_data, 0);
    acc(1'b0, A_DATA, 2'd1, 0); chk("R9 16-bit not popped", r_data, 32'hB1);
    acc(1'b1, A_MASK, 2'd3, 0); chk("R9 fatal wr", {31'b0, r_fatal}, 1);
    rd(A_MASK); chk("R9 mask kept", r_data, 32'h30);

    // R6 clear
    wr(A_CLR, 32'h10); chk("R7 no irq on clear", {31'b0, r_irq}, 0);
    rd(A_RAW); chk("R6 partial clear", r_data, 32'h20);
    rd(A_CLR); chk("R6 clr read err", {31'b0, r_err}, 1); chk("R6 clr read 0", r_data, 0);
    notify(); chk("R7 irq re-set", {31'b0, r_irq}, 1);
    wr(A_CLR, 32'h30);
    rd(A_RAW); chk("R6 full clear", r_data, 0);

    // R8 ignored writes
    wr(A_FLAG, 32'h0); wr(A_RAW, 32'h30); wr(A_MIS, 32'h30); wr(A_RSTS, 32'hFF);
    rd(A_FLAG); chk("R8 flag", r_data, 32'h80);
    rd(A_RAW);  chk("R8 raw", r_data, 0);
    rd(A_MIS);  chk("R8 mis", r_data, 0);
    rd(A_RSTS); chk("R8 rsts", r_data, 0);

    // R5 mask sweep with raw = both
    notify();
    for (int m = 0; m < 4; m++) begin
      wr(A_MASK, 32'(m) << 4);
      rd(A_MASK); chk("R5 mask", r_data, 32'(m) << 4);
      rd(A_MIS);  chk("R5 mis", r_data, (32'(m) << 4) & 32'h30);
    end
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK); chk("R5 unused zero", r_data, 32'h30);

    // R10 unmapped sweep
    for (int a = 0; a < 12'h50; a++) begin
      if (a == 'h00 || a == 'h04 || a == 'h18 || a == 'h38 || a == 'h3C || a == 'h40 || a == 'h44)
        continue;
      rd(12'(a));
      chk("R10 err", {31'b0, r_err}, 1);
      chk("R10 data", r_data, 0);
    end
    wr(12'h008, 32'h0); chk("R10 wr err", {31'b0, r_err}, 1);
    rd(A_MASK); chk("R10 mask kept", r_data, 32'h30);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule